// File: doc/BRIEF.md
# Wiper Step Sequencer

This block is the host-side master for a digitally stepped potentiometer that has three control lines: an active-low select, an active-low step strobe whose falling edges move the wiper by one tap, and a direction level. A client hands it one command at a time through a valid/ready handshake. A command holds a direction, a step count and a flag that says whether the final position is committed to the device's nonvolatile store. The block then produces the pin waveforms. Every setup, pulse-width and hold interval is counted in system clock cycles. When the command is finished, the block pulses `done`.

Each interval is a parameter given in nanoseconds. The block turns it into clock cycles, rounded up, using the clock-frequency parameter. The way the select line is released tells the device whether to store. The select line rises with the strobe high to store, and with the strobe low to skip the store. The long store deselect time is waited out before the next command is taken.

Top module: `wiper_seq`

## Requirements
- R1: After reset `sel_n`=1, `step_n`=1, `cmd_ready`=1, `done`=0 and `dir_up`=0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the final deselect interval has elapsed. `done` is 1 for exactly one cycle, the first cycle in which `cmd_ready` is back at 1.
- R3: While `sel_n` is 0, each falling edge of `step_n` is one wiper step, and a command gives exactly `cmd_steps` such edges. `dir_up` (1 = towards the high end, 0 = towards the low end) takes the value of `cmd_up` in the cycle after acceptance and does not change while `sel_n` is 0.
- R4: `sel_n` falls in the cycle after acceptance and stays low for exactly LEAD cycles before the first strobe falling edge. LEAD is the largest of the select setup, direction setup and strobe-high counts.
- R5: Each strobe low phase lasts exactly the strobe-low count. Each strobe high phase between steps lasts exactly HI cycles, the larger of the strobe-high and direction-hold counts.
- R6: With the store flag set, the last step is followed by a high phase and then a tail of the release count with `step_n` high. `sel_n` then rises while `step_n` is 1 and stays high for the store count before `cmd_ready` returns.
- R7: With the store flag clear, the last low phase is followed by a tail of the release count with `step_n` still low. `sel_n` then rises while `step_n` is 0 and stays high for the skip count. `step_n` returns to 1 in the same cycle that `cmd_ready` returns.
- R8: A zero-step command makes no strobe falling edge while `sel_n` is 0. Without the store flag, `step_n` is first pulled low for the select setup count while `sel_n` is still 1, and the select and deselect sequence follows. With the store flag, the select, tail and store deselect follow with `step_n` high.
- R9: Each interval in cycles is ceil(ns × CLK_HZ / 10^9), and at least 1.
- R10: `sel_n` and `step_n` never change in the same clock cycle.
- R11: `cmd_valid` and the command fields have no effect while `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_up | input | 1 | Direction: 1 up, 0 down |
| cmd_steps | input | STEP_W | Number of wiper steps |
| cmd_store | input | 1 | 1: commit final position to nonvolatile store |
| done | output | 1 | One-cycle pulse when a command has completed |
| sel_n | output | 1 | Device select, active low |
| step_n | output | 1 | Step strobe, falling edge moves wiper |
| dir_up | output | 1 | Direction level to the device |

## Verification
The bench sends a seeded random mix of directions, step counts from 0 to 7 and store flags. It adds directed cases for zero steps with and without store, a single stored step, a full 127-step run and a run driven into the low end. The exact busy length tells a missing or doubled high phase, a wrong tail level and a wrong deselect time apart from one another. The edge count and the modelled wiper position separate direction faults from step-count faults. The level of `step_n` at each select release, seen by a pin monitor, tells store from skip. Some commands offer a second command while busy, with different fields, to show that it is ignored. Two interval parameters are set to non-integral cycle values, so that the rounding is visible in the busy length.

// File: rtl/wiper_seq_pkg.sv
package wiper_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_LEAD,
    S_LOW,
    S_HIGH,
    S_TAIL,
    S_DESEL
  } wseq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned wseq_cycles(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

  function automatic int unsigned wseq_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wseq_timer.sv
module wseq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/wseq_fsm.sv
module wseq_fsm
  import wiper_seq_pkg::*;
#(
  parameter int unsigned STEP_W  = 7,
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned C_PRE   = 1,
  parameter int unsigned C_LEAD  = 1,
  parameter int unsigned C_LOW   = 1,
  parameter int unsigned C_HIGH  = 1,
  parameter int unsigned C_TAIL  = 1,
  parameter int unsigned C_STORE = 1,
  parameter int unsigned C_SKIP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              cmd_ready,
  output logic              done,
  output logic              sel_n,
  output logic              step_n,
  output logic              dir_up
);

  localparam logic [TMR_W-1:0] L_PRE   = TMR_W'(C_PRE - 1);
  localparam logic [TMR_W-1:0] L_LEAD  = TMR_W'(C_LEAD - 1);
  localparam logic [TMR_W-1:0] L_LOW   = TMR_W'(C_LOW - 1);
  localparam logic [TMR_W-1:0] L_HIGH  = TMR_W'(C_HIGH - 1);
  localparam logic [TMR_W-1:0] L_TAIL  = TMR_W'(C_TAIL - 1);
  localparam logic [TMR_W-1:0] L_STORE = TMR_W'(C_STORE - 1);
  localparam logic [TMR_W-1:0] L_SKIP  = TMR_W'(C_SKIP - 1);

  wseq_state_e       state_q, state_d;
  logic [STEP_W-1:0] rem_q, rem_d;
  logic              up_q, up_d;
  logic              store_q, store_d;
  logic              skip_q, skip_d;
  logic              done_q, done_d;

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    up_d     = up_q;
    store_d  = store_q;
    skip_d   = skip_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          up_d     = cmd_up;
          store_d  = cmd_store;
          rem_d    = cmd_steps;
          skip_d   = (cmd_steps == '0) && !cmd_store;
          tmr_load = 1'b1;
          if ((cmd_steps == '0) && !cmd_store) begin
            state_d = S_PRE;
            tmr_val = L_PRE;
          end else begin
            state_d = S_LEAD;
            tmr_val = L_LEAD;
          end
        end
      end
      S_PRE: begin
        if (tmr_expired) begin
          state_d  = S_LEAD;
          tmr_load = 1'b1;
          tmr_val  = L_LEAD;
        end
      end
      S_LEAD, S_HIGH: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (rem_q != '0) begin
            state_d = S_LOW;
            tmr_val = L_LOW;
            rem_d   = rem_q - 1'b1;
          end else begin
            state_d = S_TAIL;
            tmr_val = L_TAIL;
          end
        end
      end
      S_LOW: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if ((rem_q != '0) || store_q) begin
            state_d = S_HIGH;
            tmr_val = L_HIGH;
          end else begin
            state_d = S_TAIL;
            tmr_val = L_TAIL;
          end
        end
      end
      S_TAIL: begin
        if (tmr_expired) begin
          state_d  = S_DESEL;
          tmr_load = 1'b1;
          tmr_val  = store_q ? L_STORE : L_SKIP;
        end
      end
      S_DESEL: begin
        if (tmr_expired) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      up_q    <= 1'b0;
      store_q <= 1'b0;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      up_q    <= up_d;
      store_q <= store_d;
      skip_q  <= skip_d;
      done_q  <= done_d;
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign done      = done_q;
  assign dir_up    = up_q;
  assign sel_n     = (state_q == S_IDLE) || (state_q == S_PRE) || (state_q == S_DESEL);
  assign step_n    = (state_q == S_IDLE) || (state_q == S_HIGH)
                   || ((state_q == S_LEAD) && !skip_q)
                   || (((state_q == S_TAIL) || (state_q == S_DESEL)) && store_q);

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq
  import wiper_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned     STEP_W       = 7,
  parameter longint unsigned SEL_SETUP_NS = 100,
  parameter longint unsigned DIR_SETUP_NS = 1000,
  parameter longint unsigned LOW_NS       = 1000,
  parameter longint unsigned HIGH_NS      = 1000,
  parameter longint unsigned DIR_HOLD_NS  = 100,
  parameter longint unsigned TAIL_NS      = 1000,
  parameter longint unsigned STORE_NS     = 20_000_000,
  parameter longint unsigned SKIP_NS      = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic              done,
  output logic              sel_n,
  output logic              step_n,
  output logic              dir_up
);

  localparam int unsigned C_SEL   = wseq_cycles(SEL_SETUP_NS, CLK_HZ);
  localparam int unsigned C_DIR   = wseq_cycles(DIR_SETUP_NS, CLK_HZ);
  localparam int unsigned C_LOW   = wseq_cycles(LOW_NS, CLK_HZ);
  localparam int unsigned C_HI0   = wseq_cycles(HIGH_NS, CLK_HZ);
  localparam int unsigned C_HOLD  = wseq_cycles(DIR_HOLD_NS, CLK_HZ);
  localparam int unsigned C_TAIL  = wseq_cycles(TAIL_NS, CLK_HZ);
  localparam int unsigned C_STORE = wseq_cycles(STORE_NS, CLK_HZ);
  localparam int unsigned C_SKIP  = wseq_cycles(SKIP_NS, CLK_HZ);
  localparam int unsigned C_LEAD  = wseq_max(wseq_max(C_SEL, C_DIR), C_HI0);
  localparam int unsigned C_HIGH  = wseq_max(C_HI0, C_HOLD);
  localparam int unsigned C_MAX   = wseq_max(wseq_max(wseq_max(C_LEAD, C_LOW), C_HIGH),
                                             wseq_max(wseq_max(C_TAIL, C_STORE), C_SKIP));
  localparam int unsigned TMR_W   = $clog2(C_MAX + 1);

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;

  wseq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  wseq_fsm #(
    .STEP_W  (STEP_W),
    .TMR_W   (TMR_W),
    .C_PRE   (C_SEL),
    .C_LEAD  (C_LEAD),
    .C_LOW   (C_LOW),
    .C_HIGH  (C_HIGH),
    .C_TAIL  (C_TAIL),
    .C_STORE (C_STORE),
    .C_SKIP  (C_SKIP)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_up      (cmd_up),
    .cmd_steps   (cmd_steps),
    .cmd_store   (cmd_store),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cmd_ready   (cmd_ready),
    .done        (done),
    .sel_n       (sel_n),
    .step_n      (step_n),
    .dir_up      (dir_up)
  );

endmodule

// File: rtl/wiper_seq_chk.sv
module wiper_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic sel_n,
  input logic step_n,
  input logic dir_up
);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (sel_n && step_n)); // R1

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2

  AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && $past(!cmd_ready))); // R2

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $past(!sel_n)) |-> $stable(dir_up)); // R3

  AST_PIN_SEPARATION: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_n) |-> $stable(step_n)); // R10

endmodule

bind wiper_seq wiper_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .sel_n     (sel_n),
  .step_n    (step_n),
  .dir_up    (dir_up)
);

// File: tb/wiper_seq_tb.sv
module wiper_seq_tb;

  localparam longint unsigned HZ = 50_000_000;
  localparam int TAPS = 100;

  function automatic int cyc(longint unsigned ns);
    longint unsigned c;
    c = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // bench copies of the interval settings (tail and skip chosen non-integral)
  localparam int E_SEL   = cyc(100);
  localparam int E_DIR   = cyc(1000);
  localparam int E_LOW   = cyc(1000);
  localparam int E_HI0   = cyc(1000);
  localparam int E_HOLD  = cyc(100);
  localparam int E_TAIL  = cyc(1010);
  localparam int E_STORE = cyc(20_000);
  localparam int E_SKIP  = cyc(90);
  localparam int E_LEAD  = imax(imax(E_SEL, E_DIR), E_HI0);
  localparam int E_HIGH  = imax(E_HI0, E_HOLD);

  logic       clk, rst_n;
  logic       cmd_valid, cmd_ready, cmd_up, cmd_store, done;
  logic [6:0] cmd_steps;
  logic       sel_n, step_n, dir_up;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  wiper_seq #(
    .CLK_HZ   (HZ),
    .STEP_W   (7),
    .TAIL_NS  (1010),
    .STORE_NS (20_000),
    .SKIP_NS  (90)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_up    (cmd_up),
    .cmd_steps (cmd_steps),
    .cmd_store (cmd_store),
    .done      (done),
    .sel_n     (sel_n),
    .step_n    (step_n),
    .dir_up    (dir_up)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_busy(int n, bit st);
    if (n == 0)
      return st ? (E_LEAD + E_TAIL + E_STORE) : (E_SEL + E_LEAD + E_TAIL + E_SKIP);
    return E_LEAD + n * E_LOW + (n - 1 + int'(st)) * E_HIGH + E_TAIL + (st ? E_STORE : E_SKIP);
  endfunction

  function automatic int clamp_move(int p, bit up, int n);
    int r;
    r = up ? p + n : p - n;
    if (r < 0) r = 0;
    if (r > TAPS - 1) r = TAPS - 1;
    return r;
  endfunction

  // pin monitor: a model of the device plus minimum-interval checks
  logic prev_sel, prev_step, prev_dir;
  int   n_sel, n_step, n_dir;
  int   edges = 0, pos = 0, stored = 0, releases = 0;
  bit   first_fall, last_store, have_rel;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sel = 1'b1; prev_step = 1'b1; prev_dir = 1'b0;
      n_sel = 1000; n_step = 1000; n_dir = 1000;
      first_fall = 1'b0; have_rel = 1'b0; last_store = 1'b0;
    end else begin
      if ((sel_n != prev_sel) && (step_n != prev_step))
        chk(1'b0, "R10 sel/step same cycle", 1, 0);
      if (prev_sel && !sel_n) begin
        if (have_rel)
          chk(n_sel >= (last_store ? E_STORE : E_SKIP), last_store ? "R6 deselect" : "R7 deselect",
              n_sel, last_store ? E_STORE : E_SKIP);
        first_fall = 1'b1;
      end
      if (!prev_sel && sel_n) begin
        chk(n_step >= E_TAIL, step_n ? "R6 tail" : "R7 tail", n_step, E_TAIL);
        last_store = step_n;
        have_rel = 1'b1;
        releases++;
        if (step_n) stored = pos;
      end
      if (!sel_n && prev_step && !step_n) begin
        edges++;
        pos = clamp_move(pos, dir_up, 1);
        if (first_fall) chk(n_sel >= E_SEL, "R4 select setup", n_sel, E_SEL);
        first_fall = 1'b0;
        chk(n_dir >= E_DIR, "R4 direction setup", n_dir, E_DIR);
        chk(n_step >= E_HI0, "R5 high phase", n_step, E_HI0);
      end
      if (!sel_n && !prev_step && step_n)
        chk(n_step >= E_LOW, "R5 low phase", n_step, E_LOW);
      if ((dir_up != prev_dir) && !prev_sel)
        chk(1'b0, "R3 dir changed while selected", int'(dir_up), int'(prev_dir));
      n_sel  = (sel_n  != prev_sel)  ? 1 : n_sel + 1;
      n_step = (step_n != prev_step) ? 1 : n_step + 1;
      n_dir  = (dir_up != prev_dir)  ? 1 : n_dir + 1;
      prev_sel = sel_n; prev_step = step_n; prev_dir = dir_up;
    end
  end

  int exp_pos = 0;
  int exp_stored = 0;

  task automatic run_cmd(input bit up, input int n, input bit st, input bit inject);
    int busy, dones, e0, r0;
    bit dir_ok;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_up = up; cmd_steps = 7'(n); cmd_store = st;
    e0 = edges; r0 = releases;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0; dones = 0; dir_ok = 1'b1;
    while (!cmd_ready) begin
      if (done) dones++;
      if (dir_up != up) dir_ok = 1'b0;
      if (inject && busy >= 1 && busy <= 3) begin
        cmd_valid = 1'b1; cmd_up = ~up; cmd_steps = 7'(n + 3); cmd_store = ~st;
      end else begin
        cmd_valid = 1'b0;
      end
      busy++;
      @(negedge clk);
      if (busy > 100000) break;
    end
    cmd_valid = 1'b0;
    chk(dones == 0 && done, "R2 done in first ready cycle", int'(done), 1);
    chk(dir_ok, "R3 dir_up level", int'(dir_up), int'(up));
    chk(busy == exp_busy(n, st), (n == 0) ? "R8 busy length" : (st ? "R6 busy length" : "R7 busy length"),
        busy, exp_busy(n, st));
    chk(edges - e0 == n, (n == 0) ? "R8 no step" : "R3 step count", edges - e0, n);
    chk(releases - r0 == 1, "R2 one release", releases - r0, 1);
    exp_pos = clamp_move(exp_pos, up, n);
    chk(pos == exp_pos, "R3 wiper position", pos, exp_pos);
    if (st) exp_stored = exp_pos;
    chk(stored == exp_stored, st ? "R6 stored position" : "R7 store skipped", stored, exp_stored);
    chk(step_n == 1'b1 && sel_n == 1'b1, "R7 idle pins after command", int'(step_n), 1);
    if (inject)
      chk(busy == exp_busy(n, st) && edges - e0 == n, "R11 busy offer ignored", busy, exp_busy(n, st));
    // R9: tail and skip use non-integral ns values, seen in the busy length
    @(negedge clk);
    chk(!done, "R2 done single cycle", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_up = 1'b0; cmd_steps = '0; cmd_store = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_n && step_n && cmd_ready && !done && !dir_up, "R1 reset state",
        {27'd0, sel_n, step_n, cmd_ready, done, dir_up}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sel_n && step_n && cmd_ready && !done, "R1 idle after release", int'(cmd_ready), 1);
    chk(E_TAIL == 51 && E_SKIP == 5, "R9 rounding constants", E_TAIL, 51);
    run_cmd(1'b1, 0, 1'b0, 1'b0);     // R8 zero steps, skip
    run_cmd(1'b0, 0, 1'b1, 1'b0);     // R8 zero steps, store
    run_cmd(1'b1, 1, 1'b1, 1'b0);     // R6 single stored step
    run_cmd(1'b1, 3, 1'b0, 1'b1);     // R11 offer while busy
    run_cmd(1'b1, 127, 1'b0, 1'b0);   // R3 full count, device clamps at top
    run_cmd(1'b0, 5, 1'b1, 1'b1);
    void'($urandom(32'd20250315));
    for (int i = 0; i < 24; i++) begin
      bit u, s, inj;
      int n;
      u   = 1'($urandom % 2);
      s   = 1'($urandom % 2);
      inj = 1'($urandom % 4 == 0);
      n   = int'($urandom % 8);
      run_cmd(u, n, s, inj);
    end
    run_cmd(1'b0, 120, 1'b0, 1'b0);   // drive into the low end
    run_cmd(1'b0, 2, 1'b1, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule